// File: doc/BRIEF.md
# Multiphase Complementary PWM Generator with Dead-Time

The block drives a set of power-stage phases, each with a high-side and a low-side switch command. Every phase has its own free-running counter and its own half-duty value, and places its edges symmetrically about the counter wrap. The high-side pulse is centred on the wrap point. The low-side pulse sits in the middle of the period. The low-side edges are moved inward from the high-side edges by a fixed dead-time count, so the two switches of a leg are never commanded on together.

The counters start staggered so that the phases follow one another evenly, with phase 0 leading. After reset every output stays low. A phase's high side may first assert only after that phase's counter has wrapped once, and its low side only after its own high side has asserted once. The half-duty register clears on reset, and reloads only at the counter wrap.

The period and the dead-time are elaboration parameters. The half-duty values arrive on one packed input, with phase k in bits [k*CW +: CW], where CW = $clog2(PERIOD).

Top module: `cpwm_top`

## Requirements
- R1: Reset is synchronous and active low. While it is held and in the cycle after release, every output is 0. Phase k's counter restarts at PERIOD-1-k*(PERIOD/PHASES), so phase k+1's first high pulse begins exactly PERIOD/PHASES cycles after phase k's.
- R2: Each counter steps 0,1,...,PERIOD-1 and then returns to 0, so high-side rising edges of a phase repeat every PERIOD cycles.
- R3: The half-duty register of a phase clears on reset. It loads its input only in the cycle the counter reads PERIOD-1, and the new value applies from count 0. Inputs above PERIOD/2-1 are stored as PERIOD/2-1.
- R4: The high output is 0 in the cycle after the count equals the half-duty value h. It is 1 in the cycle after the count equals PERIOD-h, and the clear takes priority. In steady state the high pulse is 2h cycles wide, and with h=0 the high side stays off.
- R5: The low output is 1 in the cycle after the count equals h+DEAD. It is 0 in the cycle after the count equals PERIOD-DEAD-h. In steady state the low pulse is PERIOD-2h-2*DEAD cycles wide.
- R6: Each phase has its own low-side enable that clears on reset and sets when that phase's high output rises. The low output cannot rise while the enable is clear, so the first low pulse of a phase follows its first high pulse.
- R7: When 2*(h+DEAD) >= PERIOD, the low output of that phase stays 0.
- R8: The high and low outputs of a phase are never 1 in the same cycle. Between one of them falling and the other rising there are at least DEAD cycles with both at 0.
- R9: A phase's high output cannot rise before its counter has wrapped once since reset, so phase k's first high pulse comes before phase k+1's.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| half_duty | input | PHASES*CW | Half-duty per phase, phase k in bits [k*CW +: CW] |
| hi_out | output | PHASES | High-side commands, bit k for phase k |
| lo_out | output | PHASES | Low-side commands, bit k for phase k |

## Verification
A counter started at the wrong value, or one that wraps at the wrong count, moves a phase's edges. That shows within one period as a wrong stagger between the first high pulses, or as a wrong spacing between rising edges. A half-duty register that loads at the wrong time, or an edge compare that is wrong, changes the pulse widths or the dead gaps on the very next pulse. A per-cycle reference of both outputs of every phase catches this in the cycle it happens. A low-side enable that is wrongly shared or wrongly set shows after a reset with one phase held at zero duty: that phase's low side then switches although its high side never rose.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;

    typedef enum logic [1:0] {
        EV_HOLD = 2'd0,
        EV_RISE = 2'd1,
        EV_FALL = 2'd2
    } pin_ev_e;

    function automatic int start_count(int period, int phases, int k);
        return period - 1 - k * (period / phases);
    endfunction

    function automatic int duty_limit(int period);
        return period / 2 - 1;
    endfunction

    function automatic logic apply_ev(logic cur, pin_ev_e ev);
        case (ev)
            EV_RISE: return 1'b1;
            EV_FALL: return 1'b0;
            default: return cur;
        endcase
    endfunction

endpackage

// File: rtl/cpwm_counter.sv
module cpwm_counter
    import cpwm_pkg::*;
#(
    parameter int PERIOD = 40,
    parameter int START  = 39,
    parameter int CW     = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [CW-1:0] cnt_o,
    output logic          wrap_o,
    output logic          armed_o
);
    localparam logic [CW-1:0] LAST    = CW'(PERIOD - 1);
    localparam logic [CW-1:0] START_V = CW'(START);

    assign wrap_o = (cnt_o == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_o   <= START_V;
            armed_o <= 1'b0;
        end else if (wrap_o) begin
            cnt_o   <= '0;
            armed_o <= 1'b1;
        end else begin
            cnt_o   <= cnt_o + 1'b1;
        end
    end

    // R2
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_o <= LAST);

    // R2
    cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |=> (cnt_o == '0));

    // R9
    arm_after_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed_o) |-> $past(wrap_o));

endmodule

// File: rtl/cpwm_duty_reg.sv
module cpwm_duty_reg
    import cpwm_pkg::*;
#(
    parameter int PERIOD = 40,
    parameter int CW     = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wrap_i,
    input  logic [CW-1:0] hd_i,
    output logic [CW-1:0] hd_o
);
    localparam logic [CW-1:0] LIM = CW'(duty_limit(PERIOD));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hd_o <= '0;
        end else if (wrap_i) begin
            hd_o <= (hd_i > LIM) ? LIM : hd_i;
        end
    end

    // R3
    hd_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hd_o <= LIM);

    // R3
    hd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap_i |=> $stable(hd_o));

endmodule

// File: rtl/cpwm_outpair.sv
module cpwm_outpair
    import cpwm_pkg::*;
#(
    parameter int PERIOD = 40,
    parameter int DEAD   = 3,
    parameter int CW     = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          armed_i,
    input  logic [CW-1:0] cnt_i,
    input  logic [CW-1:0] hd_i,
    output logic          hi_o,
    output logic          lo_o
);
    logic    en_q;
    logic    hi_set, hi_clr, lo_set, lo_clr, lo_ok;
    int      c, h;
    pin_ev_e hi_ev, lo_ev;

    always_comb begin
        c      = int'(cnt_i);
        h      = int'(hd_i);
        hi_clr = (c == h);
        hi_set = armed_i && (c == PERIOD - h);
        lo_ok  = (2 * (h + DEAD)) < PERIOD;
        lo_set = en_q && (c == h + DEAD);
        lo_clr = (c == PERIOD - DEAD - h);

        if (hi_clr)      hi_ev = EV_FALL;
        else if (hi_set) hi_ev = EV_RISE;
        else             hi_ev = EV_HOLD;

        if (!lo_ok)      lo_ev = EV_FALL;
        else if (lo_set) lo_ev = EV_RISE;
        else if (lo_clr) lo_ev = EV_FALL;
        else             lo_ev = EV_HOLD;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_o <= 1'b0;
            lo_o <= 1'b0;
            en_q <= 1'b0;
        end else begin
            hi_o <= apply_ev(hi_o, hi_ev);
            lo_o <= apply_ev(lo_o, lo_ev);
            if (hi_ev == EV_RISE) en_q <= 1'b1;
        end
    end

    // R8
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hi_o && lo_o));

    // R8
    hi_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hi_o) |-> !lo_o);

    // R8
    lo_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lo_o) |-> !hi_o);

    // R6
    lo_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lo_o) |-> en_q);

    // R7
    lo_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lo_o |-> lo_ok);

    // R9
    hi_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hi_o) |-> armed_i);

endmodule

// File: rtl/cpwm_top.sv
module cpwm_top
    import cpwm_pkg::*;
#(
    parameter int PHASES = 2,
    parameter int PERIOD = 40,
    parameter int DEAD   = 3,
    localparam int CW    = $clog2(PERIOD)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [PHASES*CW-1:0] half_duty,
    output logic [PHASES-1:0]    hi_out,
    output logic [PHASES-1:0]    lo_out
);

    for (genvar g = 0; g < PHASES; g++) begin : g_phase
        localparam int START = start_count(PERIOD, PHASES, g);

        logic [CW-1:0] cnt;
        logic [CW-1:0] hd;
        logic          wrap;
        logic          armed;

        cpwm_counter #(.PERIOD(PERIOD), .START(START), .CW(CW)) u_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .cnt_o   (cnt),
            .wrap_o  (wrap),
            .armed_o (armed)
        );

        cpwm_duty_reg #(.PERIOD(PERIOD), .CW(CW)) u_duty (
            .clk    (clk),
            .rst_n  (rst_n),
            .wrap_i (wrap),
            .hd_i   (half_duty[g*CW +: CW]),
            .hd_o   (hd)
        );

        cpwm_outpair #(.PERIOD(PERIOD), .DEAD(DEAD), .CW(CW)) u_pair (
            .clk     (clk),
            .rst_n   (rst_n),
            .armed_i (armed),
            .cnt_i   (cnt),
            .hd_i    (hd),
            .hi_o    (hi_out[g]),
            .lo_o    (lo_out[g])
        );
    end

endmodule

// File: tb/cpwm_top_test.sv
module cpwm_top_test;
    localparam int PH  = 2;
    localparam int P   = 40;
    localparam int D   = 3;
    localparam int CW  = $clog2(P);
    localparam int LIM = P / 2 - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [PH*CW-1:0] hd_vec = '0;
    logic [PH-1:0] hi_out, lo_out;

    cpwm_top #(.PHASES(PH), .PERIOD(P), .DEAD(D)) uut (
        .clk(clk), .rst_n(rst_n), .half_duty(hd_vec),
        .hi_out(hi_out), .lo_out(lo_out)
    );

    always #10 clk = ~clk;

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;
    int wd = 0;
    int cyc = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // reference model, built from the requirements
    int m_cnt[PH], m_hd[PH];
    bit m_arm[PH], m_en[PH], m_hi[PH], m_lo[PH];
    logic [2*PH-1:0] exp_q[$];

    always @(posedge clk) begin
        logic [2*PH-1:0] e;
        for (int p = 0; p < PH; p++) begin
            if (!rst_n) begin
                m_cnt[p] = P - 1 - p * (P / PH);
                m_hd[p] = 0; m_arm[p] = 0; m_en[p] = 0; m_hi[p] = 0; m_lo[p] = 0;
            end else begin
                int c, h, inp;
                bit nhi, nlo;
                c = m_cnt[p]; h = m_hd[p];
                nhi = m_hi[p];
                if (c == h) nhi = 0;
                else if (m_arm[p] && c == P - h) nhi = 1;
                nlo = m_lo[p];
                if (2 * (h + D) >= P) nlo = 0;
                else if (m_en[p] && c == h + D) nlo = 1;
                else if (c == P - D - h) nlo = 0;
                if (nhi && !m_hi[p]) m_en[p] = 1;
                m_hi[p] = nhi; m_lo[p] = nlo;
                if (c == P - 1) begin
                    inp = int'(hd_vec[p*CW +: CW]);
                    m_hd[p] = (inp > LIM) ? LIM : inp;
                    m_arm[p] = 1;
                    m_cnt[p] = 0;
                end else begin
                    m_cnt[p] = c + 1;
                end
            end
            e[p] = m_hi[p];
            e[PH+p] = m_lo[p];
        end
        exp_q.push_back(e);
    end

    // monitor records
    int first_hi[PH], first_lo[PH], last_hi_w[PH], last_lo_w[PH];
    int hi_per[PH], last_rise[PH], hi_run[PH], lo_run[PH], idle[PH], last_act[PH];
    bit hi_seen[PH], lo_seen[PH], prev_hi[PH], prev_lo[PH];

    task automatic clear_rec();
        for (int p = 0; p < PH; p++) begin
            first_hi[p] = -1; first_lo[p] = -1; last_hi_w[p] = -1; last_lo_w[p] = -1;
            hi_per[p] = -1; last_rise[p] = -1; hi_run[p] = 0; lo_run[p] = 0;
            idle[p] = 0; last_act[p] = 0;
        end
    endtask

    task automatic clear_window();
        for (int p = 0; p < PH; p++) begin
            hi_seen[p] = 0; lo_seen[p] = 0;
        end
    endtask

    always @(negedge clk) begin
        logic [2*PH-1:0] e;
        cyc++;
        if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            for (int p = 0; p < PH; p++) begin
                chk(hi_out[p] == e[p], $sformatf("R4 high phase %0d", p), int'(hi_out[p]), int'(e[p]));
                chk(lo_out[p] == e[PH+p], $sformatf("R5 low phase %0d", p), int'(lo_out[p]), int'(e[PH+p]));
            end
        end
        for (int p = 0; p < PH; p++) begin
            bit hv, lv;
            hv = hi_out[p]; lv = lo_out[p];
            chk(!(hv && lv), $sformatf("R8 overlap phase %0d", p), int'(hv && lv), 0);
            if (hv && !prev_hi[p]) begin
                if (first_hi[p] < 0) first_hi[p] = cyc;
                if (last_rise[p] >= 0) hi_per[p] = cyc - last_rise[p];
                last_rise[p] = cyc;
                if (last_act[p] == 2)
                    chk(idle[p] >= D, $sformatf("R8 gap before high phase %0d", p), idle[p], D);
                last_act[p] = 1;
            end
            if (lv && !prev_lo[p]) begin
                if (first_lo[p] < 0) first_lo[p] = cyc;
                if (last_act[p] == 1)
                    chk(idle[p] >= D, $sformatf("R8 gap before low phase %0d", p), idle[p], D);
                last_act[p] = 2;
            end
            if (!hv && prev_hi[p]) begin last_hi_w[p] = hi_run[p]; hi_run[p] = 0; end
            if (!lv && prev_lo[p]) begin last_lo_w[p] = lo_run[p]; lo_run[p] = 0; end
            if (hv) hi_run[p]++;
            if (lv) lo_run[p]++;
            if (!hv && !lv) idle[p]++; else idle[p] = 0;
            if (hv) hi_seen[p] = 1;
            if (lv) lo_seen[p] = 1;
            prev_hi[p] = hv; prev_lo[p] = lv;
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic set_hd(input int h0, input int h1);
        hd_vec[0 +: CW] = CW'(h0);
        hd_vec[CW +: CW] = CW'(h1);
    endtask

    task automatic chk_widths(input int p, input int hw, input int lw);
        chk(last_hi_w[p] == hw, $sformatf("R4 high width phase %0d", p), last_hi_w[p], hw);
        chk(last_lo_w[p] == lw, $sformatf("R5 low width phase %0d", p), last_lo_w[p], lw);
    endtask

    always @(posedge clk) begin
        wd++;
        if (wd > 100000 && !done) begin
            done = 1'b1;
            nchk++; nerr++;
            $display("FAIL watchdog actual=%0d expected=%0d", wd, 100000);
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        clear_rec();
        clear_window();
        for (int p = 0; p < PH; p++) begin prev_hi[p] = 0; prev_lo[p] = 0; end
        set_hd(10, 10);
        rst_n = 1'b0;
        step(5);
        // R1: outputs low during reset
        chk(hi_out == '0 && lo_out == '0, "R1 outputs in reset", int'({hi_out, lo_out}), 0);
        rst_n = 1'b1;
        step(1);
        chk(hi_out == '0 && lo_out == '0, "R1 outputs after release", int'({hi_out, lo_out}), 0);
        step(200);
        // R9 ordering, R6 first high before first low
        chk(first_hi[0] >= 0 && first_hi[0] < first_hi[1], "R9 phase order", first_hi[1], first_hi[0]);
        for (int p = 0; p < PH; p++)
            chk(first_hi[p] >= 0 && first_hi[p] < first_lo[p],
                $sformatf("R6 high before low phase %0d", p), first_lo[p], first_hi[p]);
        chk(first_hi[1] - first_hi[0] == P / PH, "R1 stagger", first_hi[1] - first_hi[0], P / PH);
        chk(hi_per[0] == P, "R2 period phase 0", hi_per[0], P);
        chk(hi_per[1] == P, "R2 period phase 1", hi_per[1], P);
        chk_widths(0, 20, 14);
        chk_widths(1, 20, 14);

        // distinct duty per phase
        set_hd(5, 15);
        step(200);
        chk_widths(0, 10, 24);
        chk_widths(1, 30, 4);

        // R7 low suppressed at phase 0, narrow low at phase 1
        set_hd(17, 16);
        step(80);
        clear_window();
        step(120);
        chk(lo_seen[0] == 0, "R7 low off phase 0", int'(lo_seen[0]), 0);
        chk(last_hi_w[0] == 34, "R4 high width phase 0 wide", last_hi_w[0], 34);
        chk_widths(1, 32, 2);

        // R3 clamp of an out-of-range half-duty
        set_hd(60, 12);
        step(80);
        clear_window();
        step(120);
        chk(last_hi_w[0] == 2 * LIM, "R3 clamped high width", last_hi_w[0], 2 * LIM);
        chk(lo_seen[0] == 0, "R3 clamped low off", int'(lo_seen[0]), 0);
        chk_widths(1, 24, 10);

        // R6 per-phase gate: phase 1 at zero duty after a new reset
        rst_n = 1'b0;
        set_hd(10, 0);
        step(5);
        chk(hi_out == '0 && lo_out == '0, "R1 outputs in second reset", int'({hi_out, lo_out}), 0);
        clear_rec();
        clear_window();
        rst_n = 1'b1;
        step(200);
        chk(hi_seen[1] == 0, "R4 zero duty high off", int'(hi_seen[1]), 0);
        chk(lo_seen[1] == 0, "R6 low gated phase 1", int'(lo_seen[1]), 0);
        chk(lo_seen[0] == 1, "R6 phase 0 low runs", int'(lo_seen[0]), 1);
        chk_widths(0, 20, 14);
        set_hd(10, 8);
        step(200);
        chk(first_hi[1] >= 0 && first_lo[1] > first_hi[1], "R6 phase 1 release order",
            first_lo[1], first_hi[1]);
        chk_widths(1, 16, 18);

        step(4);
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end
endmodule